// File: doc/BRIEF.md
# Chip-Select Address Decoder with Overlap Resolution

This block sits on a 32-bit processor bus and classifies every access. It decides whether an access belongs to one of a fixed set of on-chip regions or to one of six programmable external areas. For an external access it produces a one-hot chip-select. It also gives the index of the area whose bus timing must be applied and an enable for stretching the cycle with a ready signal. An access that lands nowhere raises a bus-error pulse.

The external areas are programmed through a single-word write port, one configuration word per area. Areas may overlap each other, and they may overlap on-chip regions. On-chip regions always take precedence and suppress every chip-select. When two external areas both claim an address, the lower-numbered area drives the chip-select and the next matching area supplies the timing. The on-chip side does not evaluate address bits 30 and 28, so on-chip regions appear mirrored across the address map. The external side compares every address bit.

All results are registered and appear one clock after the access strobe. The bus timing engine and the memories behind the selects are separate blocks.

Top module: `cs_addr_decoder`

## Requirements
- R1: On-chip regions always win. When an access falls in one, its bit of `int_sel` is set and `cs_sel` and `bus_err` stay 0, even if an enabled external area also covers the address. The four regions are 0x00000000–0x00000FFF (bit 0), 0x000E0000–0x000FFFFF (bit 1), 0x68000000–0x6803FFFF (bit 2) and 0x80000000–0x8FFFFFFF (bit 3).
- R2: On-chip matching ignores address bits 30 and 28, so 0xC0000100 and 0x90000000 hit the bit-3 region and 0x28000000 hits the bit-2 region. External matching compares all 32 bits.
- R3: There are six external areas, numbered 0 to 5, and each has a configuration word. Bits [31:16] hold base bits [31:16]. Bits [15:12] hold a size code c, giving a size of 2^(16+c) bytes. Bit 8 turns on the double window, bit 1 enables the ready wait, and bit 0 enables the area. An address matches when it agrees with the base on every bit at or above bit 16+c.
- R4: When several enabled areas match, the lowest-numbered one drives `cs_sel`. `tim_idx` is the next-higher matching area, or the same area if only one matches.
- R5: With the double-window bit set, a second window of the same size, starting right after the aligned area, also selects that area.
- R6: `rdy_wait_en` equals the ready bit of the area named by `tim_idx`, and it is forced to 0 when that area is 4 or 5.
- R7: A valid access that hits no on-chip region and no enabled area gives `bus_err`=1 for exactly one cycle, with `cs_sel`=0 and `int_sel`=0.
- R8: An area whose enable bit is 0 never matches. After reset only area 0 is enabled, with word 0x00048003 (base 0x00040000, size 16 MB, ready wait on), so it covers 0x00000000–0x00FFFFFF.
- R9: All outputs are registered. They reflect the access presented with `acc_valid` at the previous clock edge. They are all 0, with `tim_idx`=0, after reset and after any edge without `acc_valid`.
- R10: A configuration write becomes effective at the clock edge that captures it. An access captured at that same edge is still decoded with the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Area number being written |
| cfg_wdata | input | 32 | Configuration word |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access address |
| cs_sel | output | 6 | One-hot external chip-select |
| tim_idx | output | 3 | Area whose timing applies |
| rdy_wait_en | output | 1 | Ready-signal wait extension enable |
| int_sel | output | 4 | One-hot on-chip region hit |
| bus_err | output | 1 | Unmapped-access pulse |

## Verification
The hardest case to reach is the split decision, where chip-select and timing come from different areas. It is hardest when the timing area is one of the two that never wait, because the ready result then depends on three facts at once. The stimulus builds it on purpose by programming area 3 on top of area 4, and area 0 on top of areas 1 and 3. Then it probes addresses inside the intersections. Mirrors are reached by flipping bits 30 and 28 of addresses inside on-chip and external regions. A behavioural range-based model checks every cycle, including a run of random accesses and rewrites.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

   localparam int          N_INT_REG  = 4;
   localparam logic [31:0] ALIAS_BITS = 32'h5000_0000;

   typedef struct packed {
      logic [15:0] base_hi;
      logic [3:0]  size_code;
      logic        dbl;
      logic        rdy;
      logic        en;
   } area_cfg_t;

   localparam area_cfg_t AREA_OFF   = '{16'h0000, 4'd0, 1'b0, 1'b0, 1'b0};
   localparam area_cfg_t AREA0_BOOT = '{16'h0004, 4'd8, 1'b0, 1'b1, 1'b1};

   function automatic area_cfg_t word_to_cfg(input logic [31:0] w);
      area_cfg_t c;
      c.base_hi   = w[31:16];
      c.size_code = w[15:12];
      c.dbl       = w[8];
      c.rdy       = w[1];
      c.en        = w[0];
      return c;
   endfunction

   function automatic logic [31:0] int_region_base(input int i);
      case (i)
         0:       return 32'h0000_0000;
         1:       return 32'h000E_0000;
         2:       return 32'h6800_0000;
         default: return 32'h8000_0000;
      endcase
   endfunction

   function automatic logic [31:0] int_region_mask(input int i);
      case (i)
         0:       return 32'hFFFF_F000;
         1:       return 32'hFFFE_0000;
         2:       return 32'hFFFC_0000;
         default: return 32'hF000_0000;
      endcase
   endfunction

endpackage

// File: rtl/cs_area_match.sv
module cs_area_match
   import cs_dec_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int GRAN_LSB = 16
) (
   input  area_cfg_t         cfg,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int BASE_W = ADDR_W - GRAN_LSB;

   initial begin
      assert (BASE_W == 16) else $error("base field must cover 16 address bits");
   end

   logic [ADDR_W-1:0] size_b, mask, win0, win1, base_full;
   logic              hit0, hit1;

   always_comb begin
      base_full = {cfg.base_hi, {GRAN_LSB{1'b0}}};
      size_b    = {{(ADDR_W-1){1'b0}}, 1'b1} << (GRAN_LSB + int'(cfg.size_code));
      mask      = ~(size_b - 1'b1);
      win0      = base_full & mask;
      win1      = win0 + size_b;
      hit0      = (addr & mask) == win0;
      hit1      = cfg.dbl && ((addr & mask) == win1);
      hit       = cfg.en && (hit0 || hit1);
   end

endmodule

// File: rtl/cs_int_match.sv
module cs_int_match
   import cs_dec_pkg::*;
#(
   parameter int          ADDR_W = 32,
   parameter int          N_INT  = N_INT_REG,
   parameter logic [31:0] ALIAS  = ALIAS_BITS
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [N_INT-1:0]  hit
);
   logic [ADDR_W-1:0] addr_fold;

   assign addr_fold = addr & ~ALIAS[ADDR_W-1:0];

   for (genvar g = 0; g < N_INT; g++) begin : g_reg
      localparam logic [31:0] M = int_region_mask(g);
      localparam logic [31:0] B = int_region_base(g) & ~ALIAS;
      assign hit[g] = (addr_fold & M[ADDR_W-1:0]) == (B[ADDR_W-1:0] & M[ADDR_W-1:0]);
   end

endmodule

// File: rtl/cs_prio_resolve.sv
module cs_prio_resolve #(
   parameter int N     = 6,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     match,
   output logic             any,
   output logic [IDX_W-1:0] first,
   output logic [IDX_W-1:0] second
);
   logic [N-1:0] rest;
   logic         found2;

   always_comb begin
      any    = |match;
      first  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match[i]) first = IDX_W'(i);
      end
      rest = match;
      rest[first] = 1'b0;
      second = first;
      found2 = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (rest[i]) begin
            second = IDX_W'(i);
            found2 = 1'b1;
         end
      end
   end

   // R4: timing area is never below the selecting area
   a_r4_timing_not_lower: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (second >= first));
   // R4: the selecting area really matched
   a_r4_first_matched: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> match[first]);

endmodule

// File: rtl/cs_addr_decoder.sv
module cs_addr_decoder
   import cs_dec_pkg::*;
#(
   parameter int         ADDR_W     = 32,
   parameter int         N_AREA     = 6,
   parameter int         N_INT      = N_INT_REG,
   parameter logic [5:0] NO_RDY_SET = 6'b11_0000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [2:0]                cfg_idx,
   input  logic [31:0]               cfg_wdata,
   input  logic                      acc_valid,
   input  logic [31:0]               acc_addr,
   output logic [5:0]                cs_sel,
   output logic [2:0]                tim_idx,
   output logic                      rdy_wait_en,
   output logic [3:0]                int_sel,
   output logic                      bus_err
);
   localparam int IDX_W = $clog2(N_AREA);

   initial begin
      assert (N_AREA == 6)  else $error("port widths assume six areas");
      assert (N_INT == 4)   else $error("port widths assume four on-chip regions");
      assert (ADDR_W == 32) else $error("address width must be 32");
   end

   area_cfg_t area_cfg [N_AREA];

   for (genvar g = 0; g < N_AREA; g++) begin : g_cfg
      localparam area_cfg_t RST_V = (g == 0) ? AREA0_BOOT : AREA_OFF;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    area_cfg[g] <= RST_V;
         else if (cfg_we && (int'(cfg_idx) == g))       area_cfg[g] <= word_to_cfg(cfg_wdata);
      end
   end

   logic [N_AREA-1:0] ext_hit;
   for (genvar g = 0; g < N_AREA; g++) begin : g_match
      cs_area_match #(.ADDR_W(ADDR_W), .GRAN_LSB(16)) u_match (
         .cfg  (area_cfg[g]),
         .addr (acc_addr),
         .hit  (ext_hit[g])
      );
   end

   logic [N_INT-1:0] int_hit;
   cs_int_match #(.ADDR_W(ADDR_W), .N_INT(N_INT), .ALIAS(ALIAS_BITS)) u_int (
      .addr (acc_addr),
      .hit  (int_hit)
   );

   logic             ext_any;
   logic [IDX_W-1:0] sel_i, tim_i;
   cs_prio_resolve #(.N(N_AREA), .IDX_W(IDX_W)) u_prio (
      .clk    (clk),
      .rst_n  (rst_n),
      .match  (ext_hit),
      .any    (ext_any),
      .first  (sel_i),
      .second (tim_i)
   );

   logic [5:0] cs_n;
   logic [2:0] tim_n;
   logic       rdy_n, err_n;
   logic [3:0] int_n;

   always_comb begin
      cs_n  = '0;
      tim_n = '0;
      rdy_n = 1'b0;
      err_n = 1'b0;
      int_n = '0;
      if (acc_valid) begin
         if (|int_hit) begin
            int_n = int_hit;
         end else if (ext_any) begin
            cs_n[sel_i] = 1'b1;
            tim_n       = 3'(tim_i);
            rdy_n       = area_cfg[tim_i].rdy & ~NO_RDY_SET[tim_i];
         end else begin
            err_n = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_sel      <= '0;
         tim_idx     <= '0;
         rdy_wait_en <= 1'b0;
         int_sel     <= '0;
         bus_err     <= 1'b0;
      end else begin
         cs_sel      <= cs_n;
         tim_idx     <= tim_n;
         rdy_wait_en <= rdy_n;
         int_sel     <= int_n;
         bus_err     <= err_n;
      end
   end

   a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_sel));
   a_r1_onchip_excludes_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (int_sel != 0) |-> (cs_sel == 0 && !bus_err));
   a_r7_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (cs_sel == 0 && int_sel == 0 && !rdy_wait_en));
   a_r6_no_wait_high_areas: assert property (@(posedge clk) disable iff (!rst_n)
      (tim_idx >= 3'd4) |-> !rdy_wait_en);
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (cs_sel == 0 && int_sel == 0 && !bus_err && tim_idx == 0));
   a_r9_valid_classified: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> ($countones({cs_sel != 6'd0, int_sel != 4'd0, bus_err}) == 1));

endmodule

// File: tb/tb_cs_addr_decoder.sv
`timescale 1ns/1ps
module tb_cs_addr_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [5:0]  cs_sel;
   logic [2:0]  tim_idx;
   logic        rdy_wait_en;
   logic [3:0]  int_sel;
   logic        bus_err;

   always #2.5 clk = ~clk;

   cs_addr_decoder dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .cs_sel(cs_sel), .tim_idx(tim_idx), .rdy_wait_en(rdy_wait_en),
      .int_sel(int_sel), .bus_err(bus_err)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [31:0] m_cfg [6];
   logic [14:0] exp_v;
   string       exp_tag;

   function automatic logic [31:0] mk(input logic [15:0] b, input int code,
                                      input bit dbl, input bit rdy, input bit en);
      return {b, 4'(code), 3'b000, dbl, 6'b0, rdy, en};
   endfunction

   // packed as {cs[5:0], tim[2:0], rdy, int[3:0], err}
   function automatic logic [14:0] model(input bit v, input logic [31:0] a);
      longint unsigned istart [4] = '{64'h0, 64'hE0000, 64'h68000000, 64'h80000000};
      longint unsigned ilen   [4] = '{64'h1000, 64'h20000, 64'h40000, 64'h10000000};
      longint unsigned fa, st, sz, bs;
      logic [3:0] ih = '0;
      int m1 = -1, m2 = -1;
      logic [5:0] cs = '0;
      logic [2:0] tm = '0;
      logic rd = 1'b0;
      if (!v) return '0;
      fa = longint'(a & 32'hAFFF_FFFF);
      for (int i = 0; i < 4; i++) begin
         st = istart[i] & 64'hAFFF_FFFF;
         if (fa >= st && fa < st + ilen[i]) ih[i] = 1'b1;
      end
      if (ih != 0) return {6'b0, 3'b0, 1'b0, ih, 1'b0};
      for (int k = 0; k < 6; k++) begin
         if (m_cfg[k][0]) begin
            sz = 64'd1 << (16 + m_cfg[k][15:12]);
            bs = longint'({m_cfg[k][31:16], 16'h0});
            st = bs - (bs % sz);
            if (m_cfg[k][8]) sz = sz * 2;
            if (longint'(a) >= st && longint'(a) < st + sz) begin
               if (m1 < 0) m1 = k;
               else if (m2 < 0) m2 = k;
            end
         end
      end
      if (m1 < 0) return {6'b0, 3'b0, 1'b0, 4'b0, 1'b1};
      if (m2 < 0) m2 = m1;
      cs[m1] = 1'b1;
      tm = 3'(m2);
      rd = (m2 < 4) ? m_cfg[m2][1] : 1'b0;
      return {cs, tm, rd, 4'b0, 1'b0};
   endfunction

   task automatic compare();
      logic [14:0] act;
      act = {cs_sel, tim_idx, rdy_wait_en, int_sel, bus_err};
      checks++;
      if (act !== exp_v) begin
         fails++;
         $display("FAIL %s: actual cs=%b tim=%0d rdy=%b int=%b err=%b expected cs=%b tim=%0d rdy=%b int=%b err=%b",
                  exp_tag, act[14:9], act[8:6], act[5], act[4:1], act[0],
                  exp_v[14:9], exp_v[8:6], exp_v[5], exp_v[4:1], exp_v[0]);
      end
   endtask

   task automatic cyc(input bit v, input logic [31:0] a, input bit we,
                      input int idx, input logic [31:0] wd, input string tag);
      @(negedge clk);
      compare();
      acc_valid = v;
      acc_addr  = a;
      cfg_we    = we;
      cfg_idx   = 3'(idx);
      cfg_wdata = wd;
      exp_v     = model(v, a);
      exp_tag   = tag;
      if (we) m_cfg[idx] = wd;
   endtask

   task automatic acc(input logic [31:0] a, input string tag);
      cyc(1'b1, a, 1'b0, 0, 32'h0, tag);
   endtask

   task automatic wr(input int idx, input logic [31:0] wd, input string tag);
      cyc(1'b0, 32'h0, 1'b1, idx, wd, tag);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      m_cfg[0] = 32'h0004_8003;
      for (int i = 1; i < 6; i++) m_cfg[i] = 32'h0;
      exp_v   = '0;
      exp_tag = "R9 reset state";
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R8: boot area defaults
      acc(32'h0010_0000, "R8 default area0 hit");
      acc(32'h0004_0000, "R8 default area0 base");
      acc(32'h0100_0000, "R8 beyond area0 -> R7 error");
      acc(32'h0300_0000, "R8 disabled area2 -> error");
      cyc(1'b0, 32'h0010_0000, 1'b0, 0, 0, "R9 idle after access");
      // R1: on-chip wins over area0
      acc(32'h000E_0010, "R1 boot region shadows area0");
      acc(32'h0000_0800, "R1 io region");
      acc(32'h6801_0000, "R1 ram region");
      // R10 / R3: write and access same edge
      cyc(1'b1, 32'h0300_0000, 1'b1, 2, mk(16'h0300, 0, 0, 1, 1), "R10 old cfg used");
      acc(32'h0300_0000, "R10 new cfg used R3 area2");
      acc(32'h0301_0000, "R3 outside 64KB area2");
      // R5: double window
      wr(2, mk(16'h0300, 0, 1, 1, 1), "R5 program");
      acc(32'h0301_FFFC, "R5 second window");
      acc(32'h0302_0000, "R5 past second window");
      wr(2, mk(16'h0301, 0, 1, 0, 1), "R5 program odd base");
      acc(32'h0302_0004, "R5 odd base second window");
      acc(32'h0300_0004, "R5 below odd base");
      // R4: overlaps
      wr(1, mk(16'h0000, 4, 0, 0, 1), "R4 program area1");
      wr(3, mk(16'h0020, 2, 0, 1, 1), "R4 program area3");
      acc(32'h0005_0000, "R4 area0+area1 timing area1");
      acc(32'h0021_0000, "R4 area0+area3 timing area3");
      acc(32'h0000_0010, "R4 R1 io over three areas");
      // R6: no-wait areas
      wr(4, mk(16'h7F00, 0, 0, 1, 1), "R6 program area4");
      wr(5, mk(16'h7F01, 0, 0, 1, 1), "R6 program area5");
      acc(32'h7F00_0040, "R6 area4 no wait");
      acc(32'h7F01_0040, "R6 area5 no wait");
      wr(3, mk(16'h7F00, 0, 0, 1, 1), "R6 area3 on area4");
      acc(32'h7F00_0080, "R6 R4 cs3 timing4 no wait");
      // R2: aliasing
      acc(32'hC000_0100, "R2 0xC mirror");
      acc(32'h9000_0000, "R2 0x9 mirror");
      acc(32'h2800_0000, "R2 ram mirror");
      acc(32'hA000_0000, "R2 bit29 not ignored -> error");
      acc(32'h3F00_0040, "R2 external not mirrored");
      // R7: pulse length
      acc(32'hA000_0000, "R7 error");
      cyc(1'b0, 32'h0, 1'b0, 0, 0, "R7 error one cycle");
      // R8: disable
      wr(4, mk(16'h7F00, 0, 0, 1, 0), "R8 disable area4");
      acc(32'h7F00_0040, "R8 disabled area4 falls to area3");
      wr(3, 32'h0, "R8 disable area3");
      acc(32'h7F00_0040, "R8 all disabled -> error");
      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [31:0] pool [8] = '{32'h0000_0000, 32'h000C_0000, 32'h0300_0000, 32'h6800_0000,
                                   32'h7F00_0000, 32'h8000_0000, 32'hC000_0000, 32'h0020_0000};
         logic [31:0] ad;
         ad = pool[$urandom % 8] + ($urandom & 32'h0007_FFFF);
         if (($urandom % 8) == 0) begin
            int k = $urandom % 6;
            wr(k, mk(pool[$urandom % 8][31:16] | 16'($urandom % 4), $urandom % 4,
                     1'($urandom), 1'($urandom), 1'($urandom)), "R3 random cfg");
         end else begin
            cyc(1'($urandom % 5 != 0), ad, 1'b0, 0, 0, "R4 random access");
         end
      end
      cyc(1'b0, 32'h0, 1'b0, 0, 0, "R9 final idle");
      @(negedge clk);
      compare();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule